// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block keeps two pending-interrupt vectors, one bit per processor, for up to four processors. The first vector holds software inter-processor interrupts; the second holds interval-timer interrupts. Each pending bit drives its own interrupt output line. Software sets and clears these bits through a small register port. A tick input from an external timer raises the timer interrupt on every processor at once.

The main register is a 64-bit control word. In a single write it can carry three 4-bit processor masks: one requests IPIs, one clears IPIs and one clears timer interrupts. It also carries a memory-error acknowledge bit. Three further registers give direct access:
- a register that reads the IPI vector and clears the bits written to it;
- a register that reads the timer vector and clears the bits written to it;
- a write-only register that raises IPIs from the mask written to it.

Some accesses are harmless no-ops: posting an IPI that is already pending, or clearing one that is not pending. These leave the state alone and emit a one-cycle warning pulse. A control write that carries no recognised field is flagged as an unsupported access.

Top module: `ipi_tmr_intc`

## Requirements
- R1: After reset, all outputs are zero: every interrupt line, all three flag pulses and the read data.
- R2: A write to the control register (address 0) raises the IPI line, from the next cycle, of each processor selected in bits [15:12] (bit 12 selects processor 0).
- R3: In a control write, bits [11:8] clear the pending IPI of each selected processor. When the same processor is both requested and cleared in one write, the clear wins.
- R4: In a control write, bits [7:4] clear the timer interrupt of each selected processor. The timer lines of unselected processors keep their value.
- R5: Bit 28 of a control write is a memory-error acknowledge: it is accepted and changes no state. A control write in which bits 28 and [15:4] are all zero changes no state, and `unsupported` pulses high for one cycle after it.
- R6: An IPI request for a processor that is already pending changes nothing and pulses `warn_dup_ipi`. An IPI clear for a processor that is not pending (checked after any request in the same write) pulses `warn_empty_ipi`. Both pulses last one cycle and follow the write.
- R7: A cycle with `tick` high sets the timer line of every configured processor from the next cycle. This holds even when the same cycle carries a timer clear.
- R8: A read of the control register returns, one cycle after `rd_en`, the following fields; all other bits read zero:
  - the requesting processor number `rd_cpu` in bits [1:0];
  - the timer vector in bits [7:4];
  - the IPI vector in bits [11:8].
- R9: The direct registers work as follows:
  - Address 1 reads the IPI vector in bits [3:0]; a write there clears the written bits.
  - Address 2 does the same for the timer vector.
  - A write to address 3 requests IPIs from bits [3:0].
  - Reads of any address other than 0, 1 and 2 return zero.
- R10: The following write bits have no effect, and a control write carrying only such bits counts as unsupported:
  - bits above [3:0] in writes to the direct registers;
  - control-word bits outside [15:4] and bit 28;
  - mask bits for processors at or above `NCPU`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wdata | input | 64 | Write data |
| rd_cpu | input | 2 | Number of the processor issuing the access |
| tick | input | 1 | Timer tick, one cycle per interval |
| rdata | output | 64 | Read data, registered, held between reads |
| ipi_irq | output | NCPU | Per-processor IPI interrupt lines |
| tmr_irq | output | NCPU | Per-processor timer interrupt lines |
| warn_dup_ipi | output | 1 | Pulse: IPI requested while already pending |
| warn_empty_ipi | output | 1 | Pulse: IPI cleared while not pending |
| unsupported | output | 1 | Pulse: control write with no recognised field |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. This covers the interrupt lines and the three flag pulses after a write or tick, and `rdata` after a read strobe. The driver applies each access on a falling edge and lets one rising edge pass. It then queues the expected interrupt vectors, flags and, for reads, the read word, all taken from its own model of the requirements. The monitor compares the queued items at the next falling edge, midway through the cycle in which they are due. Items are never carried over into a later cycle.

// File: rtl/ipi_tmr_intc.sv
module ipi_tmr_intc #(
  parameter int NCPU = 4,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [63:0]     wdata,
  input  logic [1:0]      rd_cpu,
  input  logic            tick,
  output logic [63:0]     rdata,
  output logic [NCPU-1:0] ipi_irq,
  output logic [NCPU-1:0] tmr_irq,
  output logic            warn_dup_ipi,
  output logic            warn_empty_ipi,
  output logic            unsupported
);
  localparam logic [3:0]    CMASK  = 4'((1 << NCPU) - 1);
  localparam logic [AW-1:0] A_CTL  = AW'(0);
  localparam logic [AW-1:0] A_IPI  = AW'(1);
  localparam logic [AW-1:0] A_TMR  = AW'(2);
  localparam logic [AW-1:0] A_IREQ = AW'(3);

  logic [3:0] ipi_q, tmr_q;
  logic [3:0] req_m, iclr_m, tclr_m, ipi_mid;
  logic ctl_wr, ipi_wr, tmr_wr, ireq_wr;
  logic unused_wbits;

  assign ctl_wr  = wr_en && addr == A_CTL;
  assign ipi_wr  = wr_en && addr == A_IPI;
  assign tmr_wr  = wr_en && addr == A_TMR;
  assign ireq_wr = wr_en && addr == A_IREQ;

  assign req_m  = CMASK & ((ctl_wr ? wdata[15:12] : 4'd0) | (ireq_wr ? wdata[3:0] : 4'd0));
  assign iclr_m = CMASK & ((ctl_wr ? wdata[11:8]  : 4'd0) | (ipi_wr  ? wdata[3:0] : 4'd0));
  assign tclr_m = CMASK & ((ctl_wr ? wdata[7:4]   : 4'd0) | (tmr_wr  ? wdata[3:0] : 4'd0));
  assign ipi_mid = ipi_q | req_m;

  assign unused_wbits = ^{wdata[63:29], wdata[27:16]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipi_q          <= '0;
      tmr_q          <= '0;
      warn_dup_ipi   <= 1'b0;
      warn_empty_ipi <= 1'b0;
      unsupported    <= 1'b0;
      rdata          <= '0;
    end else begin
      ipi_q          <= ipi_mid & ~iclr_m;
      tmr_q          <= (tmr_q & ~tclr_m) | (tick ? CMASK : 4'd0);
      warn_dup_ipi   <= |(req_m & ipi_q);
      warn_empty_ipi <= |(iclr_m & ~ipi_mid);
      unsupported    <= ctl_wr && !wdata[28] && wdata[15:4] == 12'd0;
      if (rd_en) begin
        case (addr)
          A_CTL:   rdata <= {52'd0, ipi_q, tmr_q, 2'b00, rd_cpu};
          A_IPI:   rdata <= {60'd0, ipi_q};
          A_TMR:   rdata <= {60'd0, tmr_q};
          default: rdata <= '0;
        endcase
      end
    end
  end

  assign ipi_irq = ipi_q[NCPU-1:0];
  assign tmr_irq = tmr_q[NCPU-1:0];

  a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTL) |=>
      ((ipi_irq & NCPU'($past(wdata[15:12] & ~wdata[11:8]))) == NCPU'($past(wdata[15:12] & ~wdata[11:8]))));

  a_r3_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTL) |=> ((ipi_irq & NCPU'($past(wdata[11:8]))) == '0));

  a_r4_tmr_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((tmr_irq & ~$past(tmr_irq)) == '0));

  a_r7_tick_all: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tmr_irq == {NCPU{1'b1}}));

  a_r5_unsup_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> (ipi_irq == $past(ipi_irq)));

  a_r6_dup_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    warn_dup_ipi |-> ($past(ipi_irq) != '0));

  a_r6_dup_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTL && wdata[11:8] == 4'd0) |=>
      ((ipi_irq & ~$past(ipi_irq)) == NCPU'($past(wdata[15:12] & ~{4'(ipi_irq)}))));
endmodule

// File: tb/ipi_tmr_intc_tb.sv
module ipi_tmr_intc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, tick;
  logic [AW-1:0] addr;
  logic [63:0] wdata, rdata;
  logic [1:0] rd_cpu;
  logic [3:0] ipi_irq, tmr_irq;
  logic warn_dup_ipi, warn_empty_ipi, unsupported;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_tmr_intc #(.NCPU(4), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_cpu(rd_cpu), .tick(tick), .rdata(rdata),
    .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .warn_dup_ipi(warn_dup_ipi),
    .warn_empty_ipi(warn_empty_ipi), .unsupported(unsupported));

  typedef struct {
    int          sel;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [3:0] ipi_m = '0, tmr_m = '0;

  function automatic logic [63:0] observe(int sel);
    case (sel)
      0: return rdata;
      1: return {60'd0, ipi_irq};
      2: return {60'd0, tmr_irq};
      default: return {61'd0, unsupported, warn_dup_ipi, warn_empty_ipi};
    endcase
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (observe(it.sel) !== it.exp) begin
          bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, observe(it.sel), it.exp);
        end
      end
    end
  end

  task automatic push(int sel, logic [63:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cyc(bit w, bit r, logic [AW-1:0] a, logic [63:0] d, bit t, logic [1:0] cpu, string tag);
    logic [3:0] rq, ic, tc, mid;
    logic [63:0] rexp;
    bit unsup, dup, emp;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick = t; rd_cpu = cpu;
    rq = (w && a == 0 ? d[15:12] : 4'd0) | (w && a == 3 ? d[3:0] : 4'd0);
    ic = (w && a == 0 ? d[11:8]  : 4'd0) | (w && a == 1 ? d[3:0] : 4'd0);
    tc = (w && a == 0 ? d[7:4]   : 4'd0) | (w && a == 2 ? d[3:0] : 4'd0);
    mid = ipi_m | rq;
    dup = |(rq & ipi_m);
    emp = |(ic & ~mid);
    unsup = w && a == 0 && !d[28] && d[15:4] == 12'd0;
    case (a)
      0: rexp = {52'd0, ipi_m, tmr_m, 2'b00, cpu};
      1: rexp = {60'd0, ipi_m};
      2: rexp = {60'd0, tmr_m};
      default: rexp = '0;
    endcase
    ipi_m = mid & ~ic;
    tmr_m = (tmr_m & ~tc) | (t ? 4'hF : 4'h0);
    @(posedge clk);
    push(1, {60'd0, ipi_m}, tag);
    push(2, {60'd0, tmr_m}, tag);
    push(3, {61'd0, unsup, dup, emp}, tag);
    if (r) push(0, rexp, tag);
    @(negedge clk);
    wr_en = 0; rd_en = 0; tick = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; tick = 0; addr = '0; wdata = '0; rd_cpu = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    push(0, 64'd0, "R1 reset rdata");
    push(1, 64'd0, "R1 reset ipi");
    push(2, 64'd0, "R1 reset tmr");
    push(3, 64'd0, "R1 reset flags");
    rst_n = 1;
    @(negedge clk);
    cyc(1, 0, 0, 64'h5000, 0, 0, "R2 request cpu0,cpu2");
    cyc(1, 0, 0, 64'h1000, 0, 0, "R6 duplicate request");
    cyc(1, 0, 0, 64'h0100, 0, 0, "R3 clear cpu0");
    cyc(1, 0, 0, 64'h0200, 0, 0, "R6 clear empty cpu1");
    cyc(1, 0, 0, 64'h2200, 0, 0, "R3 request+clear same cpu");
    cyc(0, 0, 0, 64'h0,    1, 0, "R7 tick");
    cyc(1, 0, 0, 64'h0050, 0, 0, "R4 clear timer cpu0,cpu2");
    cyc(1, 0, 0, 64'h00F0, 1, 0, "R7 tick with timer clear");
    cyc(1, 0, 0, 64'h0030, 0, 0, "R4 clear timer cpu0,cpu1");
    cyc(1, 0, 0, 64'h1000_0000, 0, 0, "R5 memory-error ack");
    cyc(1, 0, 0, 64'h0, 0, 0, "R5 empty control write");
    cyc(1, 0, 0, 64'h000F, 0, 0, "R5 low bits only");
    cyc(0, 1, 0, 64'h0, 0, 2, "R8 control read cpu2");
    cyc(0, 1, 0, 64'h0, 0, 3, "R8 control read cpu3");
    cyc(0, 1, 1, 64'h0, 0, 0, "R9 read ipi vector");
    cyc(1, 0, 3, 64'h3, 0, 0, "R9 direct request");
    cyc(1, 0, 1, 64'h4, 0, 0, "R9 direct ipi clear");
    cyc(0, 1, 1, 64'h0, 0, 0, "R9 read ipi after clear");
    cyc(1, 0, 2, 64'h5, 0, 0, "R9 direct timer clear");
    cyc(0, 1, 2, 64'h0, 0, 0, "R9 read timer vector");
    cyc(0, 1, 3, 64'h0, 0, 0, "R9 read request reg");
    cyc(0, 1, 5, 64'h0, 0, 0, "R9 read unmapped");
    cyc(1, 0, 3, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, "R10 upper request bits");
    cyc(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, "R10 upper clear bits");
    cyc(1, 0, 0, 64'hE000_0000_0001_000F, 0, 0, "R10 stray control bits");
    cyc(1, 1, 0, 64'h8000, 0, 1, "R2 request cpu3 with read");
    cyc(0, 1, 0, 64'h0, 0, 1, "R8 read after request");
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule